// File: doc/BRIEF.md
# LIN Slave Break Detector and Sync-Field Baud Measurement

This block sits on the receive side of a LIN slave node. It watches the serial input line, and it flags a break when the line stays low for eleven bit times at the baud rate currently in use. The break flag stays set until the host clears it. An interrupt output follows the flag whenever the interrupt enable is set.

A break also arms a single measurement of the following sync byte (0x55). The first falling edge of that byte opens a window output, and the fifth falling edge closes it. A free-running timer is captured at both edges. The difference is the length of eight bit times in clocks. The new baud divisor is that length shifted right by three, minus one. It is latched at the fifth edge and announced with a one-cycle done pulse. The host or a baud generator can then use it directly.

Top module: `lin_autobaud`

## Requirements
- R1: After reset the break flag, interrupt, window and done outputs are 0, and the divisor output is 0.
- R2: A bit time is cur_div+1 clocks. The break flag is set once the synchronised line has been low for 11 full consecutive bit times. A low period of only 10 bit times leaves the flag at 0.
- R3: Once set, the break flag stays at 1 until a one-cycle pulse on brk_clr clears it.
- R4: brk_irq is 1 exactly while both the break flag and brk_ie are 1. With brk_ie at 0 it stays 0.
- R5: The window opens only on the first falling edge after a detected break. Falling edges on a line that has seen no break open no window and produce no done pulse.
- R6: The window closes on the fifth falling edge after it opened. For a 0x55 byte sent LSB first with a start bit of 0, it is high for exactly 8 bit times in clocks.
- R7: At the fifth falling edge, new_div is loaded with (window clocks >> 3) - 1 and div_done pulses for one cycle. At all other times new_div holds its value.
- R8: The timer starts at 0 on reset and adds 1 every clock, modulo 2^TMR_W. A window that spans a timer wrap still yields the correct divisor, as if computed from (2^TMR_W + end - start).
- R9: Each break arms exactly one measurement. Falling edges after the done pulse open no new window until the next break.
- R10: Any high level on the line restarts the low-time count. Two 7-bit low periods separated by a high bit do not set the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial LIN line, idle high |
| cur_div | input | DIV_W | Current divisor: bit time is cur_div+1 clocks |
| brk_ie | input | 1 | Break interrupt enable |
| brk_clr | input | 1 | One-cycle pulse that clears the break flag |
| brk_flag | output | 1 | Break detected, sticky |
| brk_irq | output | 1 | Break interrupt request |
| sync_win | output | 1 | Measurement window, high from the 1st to the 5th sync falling edge |
| new_div | output | DIV_W | Measured divisor |
| div_done | output | 1 | One-cycle pulse when new_div is loaded |

## Verification
The line passes a two-stage synchroniser, so each result trails the bench's change of rxd by a fixed number of clocks. The break flag follows the last low clock of the eleventh bit by about three cycles. The window opens and closes three cycles after the corresponding falling edge, and div_done pulses on the same clock that the window closes. Because the window has the same delay at both ends, the bench counts its high cycles and expects exactly eight bit times. The divisor is compared through a scoreboard queue when div_done is sampled at a negative edge. Flag and interrupt checks are made only a whole bit time or more after their cause, so they do not depend on the exact latency.

// File: rtl/lin_autobaud_pkg.sv
package lin_autobaud_pkg;

  // Window length modulo 2^tw, then divided by 8 and decremented.
  function automatic logic [31:0] sync_to_div(input logic [31:0] t_open,
                                               input logic [31:0] t_close,
                                               input int unsigned tw);
    logic [31:0] span;
    logic [31:0] mask;
    mask = (tw >= 32) ? 32'hFFFF_FFFF : ((32'd1 << tw) - 32'd1);
    span = (t_close - t_open) & mask;
    return (span >> 3) - 32'd1;
  endfunction

endpackage

// File: rtl/lin_line_sync.sv
module lin_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign line = s2;
  assign fall = s3 & ~s2;
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int DIV_W    = 12,
  parameter int BRK_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic [DIV_W-1:0] cur_div,
  output logic             brk_hit
);
  localparam int NB_W = $clog2(BRK_BITS + 1);

  logic [DIV_W-1:0] bclk;
  logic [NB_W-1:0]  nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk    <= '0;
      nbits   <= '0;
      brk_hit <= 1'b0;
    end else begin
      brk_hit <= 1'b0;
      if (line) begin
        bclk  <= '0;
        nbits <= '0;
      end else if (nbits != NB_W'(BRK_BITS)) begin
        if (bclk == cur_div) begin
          bclk  <= '0;
          nbits <= nbits + 1'b1;
          if (nbits == NB_W'(BRK_BITS - 1)) brk_hit <= 1'b1;
        end else begin
          bclk <= bclk + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas
  import lin_autobaud_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int DIV_W      = 12,
  parameter int SYNC_EDGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             fall,
  output logic             armed,
  output logic             win,
  output logic             done,
  output logic [DIV_W-1:0] div_q
);
  localparam int EC_W = $clog2(SYNC_EDGES + 1);

  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] t_open;
  logic [EC_W-1:0]  ecnt;
  logic             last_edge;
  logic [31:0]      div_calc;

  assign last_edge = (ecnt == EC_W'(SYNC_EDGES - 1));
  assign div_calc  = sync_to_div(32'(t_open), 32'(timer), TMR_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer <= '0;
    else        timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      win    <= 1'b0;
      done   <= 1'b0;
      ecnt   <= '0;
      t_open <= '0;
      div_q  <= '0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        win   <= 1'b0;
        ecnt  <= '0;
      end else if (armed && fall) begin
        if (!win) begin
          win    <= 1'b1;
          t_open <= timer;
          ecnt   <= EC_W'(1);
        end else if (last_edge) begin
          win   <= 1'b0;
          armed <= 1'b0;
          done  <= 1'b1;
          div_q <= DIV_W'(div_calc);
        end else begin
          ecnt <= ecnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud #(
  parameter int DIV_W      = 12,
  parameter int TMR_W      = 16,
  parameter int BRK_BITS   = 11,
  parameter int SYNC_EDGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] cur_div,
  input  logic             brk_ie,
  input  logic             brk_clr,
  output logic             brk_flag,
  output logic             brk_irq,
  output logic             sync_win,
  output logic [DIV_W-1:0] new_div,
  output logic             div_done
);
  // Internal events, named for the checker.
  logic line_s;
  logic line_fall;
  logic brk_hit;
  logic meas_armed;

  lin_line_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .rxd  (rxd),
    .line (line_s),
    .fall (line_fall)
  );

  lin_brk_det #(.DIV_W(DIV_W), .BRK_BITS(BRK_BITS)) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .line   (line_s),
    .cur_div(cur_div),
    .brk_hit(brk_hit)
  );

  lin_sync_meas #(.TMR_W(TMR_W), .DIV_W(DIV_W), .SYNC_EDGES(SYNC_EDGES)) u_meas (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (brk_hit),
    .fall (line_fall),
    .armed(meas_armed),
    .win  (sync_win),
    .done (div_done),
    .div_q(new_div)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       brk_flag <= 1'b0;
    else if (brk_hit) brk_flag <= 1'b1;
    else if (brk_clr) brk_flag <= 1'b0;
  end

  assign brk_irq = brk_flag & brk_ie;
endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk_flag,
  input logic             brk_clr,
  input logic             brk_ie,
  input logic             brk_irq,
  input logic             brk_hit,
  input logic             sync_win,
  input logic             div_done,
  input logic             meas_armed,
  input logic [DIV_W-1:0] new_div
);
  a_r2_flag_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(brk_hit));

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr) |=> brk_flag);

  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_ie |-> !brk_irq);

  a_r5_win_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_win) |-> $past(meas_armed));

  a_r6_done_closes_win: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (!sync_win && $past(sync_win)));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> !div_done);

  a_r7_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !div_done |-> $stable(new_div));

  a_r9_disarm_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> !meas_armed);
endmodule

bind lin_autobaud lin_autobaud_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .brk_flag  (brk_flag),
  .brk_clr   (brk_clr),
  .brk_ie    (brk_ie),
  .brk_irq   (brk_irq),
  .brk_hit   (brk_hit),
  .sync_win  (sync_win),
  .div_done  (div_done),
  .meas_armed(meas_armed),
  .new_div   (new_div)
);

// File: tb/lin_autobaud_tb.sv
module lin_autobaud_tb;
  localparam int DIV_W = 12;
  localparam int WRAP_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic [DIV_W-1:0] cur_div = '0;
  logic brk_ie = 1'b0;
  logic brk_clr = 1'b0;

  logic brk_flag, brk_irq, sync_win, div_done;
  logic [DIV_W-1:0] new_div;
  logic w_flag, w_irq, w_win, w_done;
  logic [DIV_W-1:0] w_div;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int win_len = 0;
  int exp_win = 0;
  int win_rises = 0;
  logic win_prev = 1'b0;
  logic finished = 1'b0;
  logic [DIV_W-1:0] q_main[$];
  logic [DIV_W-1:0] q_wrap[$];

  always #5 clk = ~clk;

  lin_autobaud #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cur_div(cur_div), .brk_ie(brk_ie),
    .brk_clr(brk_clr), .brk_flag(brk_flag), .brk_irq(brk_irq),
    .sync_win(sync_win), .new_div(new_div), .div_done(div_done));

  lin_autobaud #(.DIV_W(DIV_W), .TMR_W(WRAP_W)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cur_div(cur_div), .brk_ie(brk_ie),
    .brk_clr(brk_clr), .brk_flag(w_flag), .brk_irq(w_irq),
    .sync_win(w_win), .new_div(w_div), .div_done(w_done));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Monitor: scoreboard pops and window-length measurement.
  always @(negedge clk) begin
    if (rst_n) begin
      if (div_done) begin
        if (q_main.size() == 0) check("R7 unexpected done", 1, 0);
        else check("R7 divisor", int'(new_div), int'(q_main.pop_front()));
      end
      if (w_done) begin
        if (q_wrap.size() == 0) check("R8 unexpected done", 1, 0);
        else check("R8 divisor across wrap", int'(w_div), int'(q_wrap.pop_front()));
      end
      if (sync_win && !win_prev) win_rises++;
      if (sync_win) win_len++;
      else if (win_len != 0) begin
        check("R6 window length", win_len, exp_win);
        win_len = 0;
      end
      win_prev = sync_win;
    end
  end

  task automatic hold(input logic v, input int nbits, input int bt);
    rxd = v;
    repeat (nbits * bt) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int bt);
    hold(1'b0, 1, bt);
    for (int i = 0; i < 8; i++) hold(b[i], 1, bt);
    hold(1'b1, 1, bt);
  endtask

  task automatic pulse_clr();
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    @(negedge clk);
  endtask

  // Driver: break, delimiter, sync byte; expected results pushed first.
  task automatic frame(input int bt);
    cur_div = DIV_W'(bt - 1);
    pulse_clr();
    hold(1'b0, 13, bt);
    check("R2 flag after 13-bit break", int'(brk_flag), 1);
    hold(1'b1, 1, bt);
    exp_win = 8 * bt;
    q_main.push_back(DIV_W'(bt - 1));
    q_wrap.push_back(DIV_W'(bt - 1));
    send_byte(8'h55, bt);
    hold(1'b1, 3, bt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rises;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag", int'(brk_flag), 0);
    check("R1 irq", int'(brk_irq), 0);
    check("R1 window", int'(sync_win), 0);
    check("R1 done", int'(div_done), 0);
    check("R1 divisor", int'(new_div), 0);

    cur_div = DIV_W'(49);
    hold(1'b0, 7, 50); hold(1'b1, 1, 50); hold(1'b0, 7, 50); hold(1'b1, 3, 50);
    check("R10 split low periods", int'(brk_flag), 0);
    hold(1'b0, 10, 50); hold(1'b1, 3, 50);
    check("R2 ten-bit low", int'(brk_flag), 0);

    send_byte(8'h55, 50); hold(1'b1, 3, 50);
    check("R5 no window without break", win_rises, 0);

    frame(50);
    check("R3 flag held after sync", int'(brk_flag), 1);
    check("R4 irq off while disabled", int'(brk_irq), 0);
    brk_ie = 1'b1;
    @(negedge clk);
    check("R4 irq on", int'(brk_irq), 1);
    pulse_clr();
    check("R3 flag cleared", int'(brk_flag), 0);
    check("R4 irq follows clear", int'(brk_irq), 0);

    rises = win_rises;
    send_byte(8'h55, 50); hold(1'b1, 3, 50);
    check("R9 no second window", win_rises, rises);
    check("R9 no pending result", q_main.size(), 0);

    frame(37);
    frame(20);

    while ((cyc % (1 << WRAP_W)) != 650) @(negedge clk);
    frame(20);

    hold(1'b1, 2, 20);
    check("R7 all results seen", q_main.size(), 0);
    check("R8 all results seen", q_wrap.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule